// File: doc/BRIEF.md
# Instruction Fetch Alignment Penalty Calculator

This block estimates the extra issue cycles an instruction costs because of where it sits inside a 32-byte fetch block. It sits beside an instruction stream. For each instruction the stream presents the byte address, whether the instruction is one or two dwords long, its base execution cycles, and flags that mark a jump target, the direction of that jump, a conditional branch, and whether the branch was taken. The block works out the dword slot of the instruction inside its fetch block and applies a set of slot rules. Each penalty unit costs four cycles.

Three rules add penalty units. A two-dword instruction placed late in a block adds one unit. A forward jump landing late in a block adds units that grow with the slot. A conditional branch that falls through in the second half of a block adds units that also grow with the slot. A long-running previous instruction can hide the fetch of a following two-dword instruction, and so can a long two-dword instruction followed closely by another two-dword one. A mode input selects newer cache-resident fetch, in which every penalty is zero. A mask input models occupancy hiding. When it is set, the reported penalty is zero but a separate raw total still counts it.

Each accepted instruction produces a one-cycle result pulse on the next clock. Two running totals are kept: one for the reported penalties and one for the raw penalties.

Top module: `ifp_align_penalty`

## Requirements
- R1: During synchronous active-low reset `in_ready` and `pen_valid` are 0 and both totals are 0. `in_ready` is 1 from the first clock edge after reset is released and stays 1.
- R2: An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `pen_valid` is 1 during exactly the cycle after each acceptance. In a cycle with no acceptance before it, `pen_valid` is 0 and both totals hold their values.
- R3: The slot N is `in_addr[4:2]`, and `in_addr[1:0]` is ignored. In older mode, a one-dword instruction adds no size penalty. A two-dword instruction at N = 0 or 1 adds none. A two-dword instruction at N = 2..7 adds one unit.
- R4: Take a previous accepted instruction at dword address P with base cycles C > 4. A two-dword instruction that is not a jump target and whose last dword lies below P + C/4 has no size penalty.
- R5: Take a previous accepted two-dword instruction at dword address P with C >= 16. A two-dword instruction at dword address D, not a jump target, with P < D <= P + 4, has no size penalty.
- R6: A forward jump target at N > 4 adds N-4 units. It adds none at N <= 4. A backward jump target (`in_backward` = 1) never adds target units.
- R7: A conditional branch that is not taken at N >= 4 adds N-3 units. A taken branch, or one at N < 4, adds none.
- R8: Size, target and branch units add together. `pen_cycles` equals 4 times the sum, so the worst case is 8 units (32 cycles).
- R9: With `mode_cached` = 1, `pen_cycles` is 0 and neither total changes for that instruction.
- R10: With `mask_en` = 1 in older mode, `pen_cycles` is 0 and `pen_total` is unchanged, while `raw_total` still adds the unmasked penalty.
- R11: `pen_total` is the sum of all reported `pen_cycles`. `raw_total` is the sum of the unmasked older-mode penalties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction descriptor present |
| in_ready | output | 1 | Block accepts a descriptor |
| in_addr | input | 16 | Instruction byte address |
| in_two_dw | input | 1 | 1 = two-dword instruction, 0 = one dword |
| in_base_cyc | input | 8 | Base execution cycles |
| in_is_target | input | 1 | Instruction is a jump target |
| in_backward | input | 1 | Jump into this target went backward |
| in_is_cond | input | 1 | Instruction is a conditional branch |
| in_taken | input | 1 | Conditional branch was taken |
| mode_cached | input | 1 | 1 = cache-resident fetch, no penalties |
| mask_en | input | 1 | Occupancy hides penalties from the report |
| pen_valid | output | 1 | Result pulse, one cycle after acceptance |
| pen_cycles | output | 6 | Penalty cycles of the last accepted instruction |
| pen_total | output | 24 | Sum of reported penalty cycles |
| raw_total | output | 24 | Sum of unmasked penalty cycles |

## Verification
The assertions check on every cycle:
- the acceptance-to-pulse timing and the idle-cycle holding of both totals;
- that the reported total grows by exactly the emitted penalty;
- that cached mode and masking zero the output and that cached mode leaves the raw total alone;
- that one-dword plain instructions and backward targets cost nothing.

The slot-dependent unit counts for size, target and branch are shown only by the bench. It sweeps every slot against every flag combination in each mode, and it runs short directed sequences for the previous-instruction rules. Those sequences include the edge of each free window and the fact that a jump target cancels it.

// File: rtl/ifp_pkg.sv
// Package: shared constants and the fetch-mode type of the alignment
// penalty calculator.
package ifp_pkg;
    localparam int UNIT_SHIFT = 2;  // one penalty unit = 4 cycles
    localparam int DW_SHIFT   = 2;  // 4 bytes per dword

    typedef enum logic {
        FETCH_LEGACY = 1'b0,
        FETCH_CACHED = 1'b1
    } fetch_mode_e;
endpackage

// File: rtl/ifp_slot_rules.sv
// Module: ifp_slot_rules
// Purely combinational. It turns the slot of an instruction and its flags
// into penalty units. Assumes UNIT_W is wide enough for the sum of all three
// rules (SLOT_W+1 bits for the default thresholds).
module ifp_slot_rules #(
    parameter int SLOT_W    = 3,
    parameter int WIDE_FREE = 2,   // two-dword starts below this slot are free
    parameter int TGT_FREE  = 5,   // targets below this slot are free
    parameter int COND_FREE = 4,   // branches below this slot are free
    parameter int UNIT_W    = 4
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic              two_dw,
    input  logic              seq_free,
    input  logic              is_target,
    input  logic              backward,
    input  logic              is_cond,
    input  logic              taken,
    output logic [UNIT_W-1:0] units
);
    logic [UNIT_W-1:0] slot_x;
    logic [UNIT_W-1:0] size_u;
    logic [UNIT_W-1:0] tgt_u;
    logic [UNIT_W-1:0] cond_u;

    assign slot_x = UNIT_W'(slot);

    // Size rule: late two-dword instructions cost one unit unless hidden.
    always_comb begin
        size_u = '0;
        if (two_dw && (int'(slot) >= WIDE_FREE) && !seq_free)
            size_u = UNIT_W'(1);
    end

    // Target rule: forward targets late in the block cost (slot - (TGT_FREE-1)).
    always_comb begin
        tgt_u = '0;
        if (is_target && !backward && (int'(slot) >= TGT_FREE))
            tgt_u = slot_x - UNIT_W'(TGT_FREE - 1);
    end

    // Branch rule: fall-through branches in the late half cost (slot - (COND_FREE-1)).
    always_comb begin
        cond_u = '0;
        if (is_cond && !taken && (int'(slot) >= COND_FREE))
            cond_u = slot_x - UNIT_W'(COND_FREE - 1);
    end

    // Sum of the three independent rules.
    assign units = size_u + tgt_u + cond_u;
endmodule

// File: rtl/ifp_seq_tracker.sv
// Module: ifp_seq_tracker
// Remembers the previous accepted instruction and decides whether the fetch
// of the current two-dword instruction is hidden. It is hidden either by the
// previous instruction's long run (a window of C/4 dwords from its start) or
// by the long two-dword chaining rule. Assumes the stream is sequential
// unless the jump-target flag is set; a jump target is never hidden.
module ifp_seq_tracker #(
    parameter int DW_W       = 14,
    parameter int CYC_W      = 8,
    parameter int WIDE_CYC   = 16,
    parameter int CHAIN_WIN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DW_W-1:0]   dw,
    input  logic              two_dw,
    input  logic [CYC_W-1:0]  cyc,
    input  logic              is_target,
    output logic              seq_free
);
    import ifp_pkg::*;

    localparam int UNIT_CYC = 1 << UNIT_SHIFT;

    logic              have_q;
    logic [DW_W:0]     free_end_q;
    logic              chain_q;
    logic [DW_W-1:0]   chain_dw_q;

    logic [DW_W:0]     cur_end;
    logic [DW_W:0]     next_free_end;
    logic [DW_W-1:0]   chain_gap;
    logic              win_ok;
    logic              chain_ok;

    // End (exclusive) of the current instruction in dword address space.
    assign cur_end = {1'b0, dw} + (two_dw ? (DW_W+1)'(2) : (DW_W+1)'(1));

    // Window that the current instruction will hide for its successor.
    assign next_free_end = (int'(cyc) > UNIT_CYC)
                         ? {1'b0, dw} + (DW_W+1)'(cyc >> UNIT_SHIFT)
                         : {1'b0, dw};

    assign chain_gap = dw - chain_dw_q;

    // Hiding decision for the instruction being presented.
    always_comb begin
        win_ok   = have_q && (cur_end <= free_end_q);
        chain_ok = have_q && chain_q && two_dw && (dw > chain_dw_q)
                && (int'(chain_gap) <= CHAIN_WIN);
        seq_free = !is_target && (win_ok || chain_ok);
    end

    // Capture the timing footprint of each accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q     <= 1'b0;
            free_end_q <= '0;
            chain_q    <= 1'b0;
            chain_dw_q <= '0;
        end else if (accept) begin
            have_q     <= 1'b1;
            free_end_q <= next_free_end;
            chain_q    <= two_dw && (int'(cyc) >= WIDE_CYC);
            chain_dw_q <= dw;
        end
    end

    // R4/R5: nothing is hidden before any instruction has been seen.
    a_r4_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        seq_free |-> have_q);
    // R4/R5: a jump target is never hidden by the previous instruction.
    a_r5_target_not_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        is_target |-> !seq_free);
endmodule

// File: rtl/ifp_accum.sv
// Module: ifp_accum
// Registers the per-instruction penalty and keeps the reported and raw
// running totals. Assumes units is already zero-extended to the result width
// by the caller's parameters; the totals wrap at TOT_W bits.
module ifp_accum #(
    parameter int UNIT_W = 4,
    parameter int PEN_W  = 6,
    parameter int TOT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [UNIT_W-1:0] units,
    input  logic              zero_pen,   // cached mode or masked
    input  logic              raw_block,  // cached mode
    output logic              pen_valid,
    output logic [PEN_W-1:0]  pen_cycles,
    output logic [TOT_W-1:0]  pen_total,
    output logic [TOT_W-1:0]  raw_total
);
    import ifp_pkg::*;

    logic [PEN_W-1:0] full_pen;
    logic [PEN_W-1:0] shown_pen;

    // Convert units to cycles; cached or masked reports show zero.
    assign full_pen  = PEN_W'(units) << UNIT_SHIFT;
    assign shown_pen = zero_pen ? '0 : full_pen;

    // Result pulse, reported penalty and the two running totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_valid  <= 1'b0;
            pen_cycles <= '0;
            pen_total  <= '0;
            raw_total  <= '0;
        end else begin
            pen_valid <= accept;
            if (accept) begin
                pen_cycles <= shown_pen;
                pen_total  <= pen_total + TOT_W'(shown_pen);
                if (!raw_block)
                    raw_total <= raw_total + TOT_W'(full_pen);
            end
        end
    end

    a_r2_pulse_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pen_valid);
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!pen_valid && $stable(pen_total) && $stable(raw_total)));
    a_r11_total_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pen_total == $past(pen_total) + TOT_W'(pen_cycles)));
    a_r9_zeroed_report: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && zero_pen) |=> (pen_cycles == '0));
    a_r9_raw_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && raw_block) |=> $stable(raw_total));
endmodule

// File: rtl/ifp_align_penalty.sv
// Module: ifp_align_penalty (top)
// Estimates fetch-alignment penalty cycles per instruction inside a fixed-size
// fetch block, and keeps reported and raw running totals. One descriptor can
// be accepted per cycle; the result appears on the following cycle. Assumes
// BLOCK_BYTES is a power of two of at least 8 dwords for the default
// thresholds.
module ifp_align_penalty #(
    parameter int ADDR_W      = 16,
    parameter int CYC_W       = 8,
    parameter int TOT_W       = 24,
    parameter int BLOCK_BYTES = 32,
    parameter int WIDE_FREE   = 2,
    parameter int TGT_FREE    = 5,
    parameter int COND_FREE   = 4,
    parameter int WIDE_CYC    = 16,
    parameter int CHAIN_WIN   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic                    in_two_dw,
    input  logic [CYC_W-1:0]        in_base_cyc,
    input  logic                    in_is_target,
    input  logic                    in_backward,
    input  logic                    in_is_cond,
    input  logic                    in_taken,
    input  logic                    mode_cached,
    input  logic                    mask_en,
    output logic                    pen_valid,
    output logic [ifp_pkg::UNIT_SHIFT+$clog2(BLOCK_BYTES/4):0] pen_cycles,
    output logic [TOT_W-1:0]        pen_total,
    output logic [TOT_W-1:0]        raw_total
);
    import ifp_pkg::*;

    localparam int BLK_DW = BLOCK_BYTES >> DW_SHIFT;
    localparam int SLOT_W = $clog2(BLK_DW);
    localparam int DW_W   = ADDR_W - DW_SHIFT;
    localparam int UNIT_W = SLOT_W + 1;
    localparam int PEN_W  = UNIT_W + UNIT_SHIFT;

    logic              ready_q;
    logic              accept;
    logic [SLOT_W-1:0] slot;
    logic [DW_W-1:0]   dw;
    logic              seq_free;
    logic [UNIT_W-1:0] units;
    fetch_mode_e       mode_e;
    logic              zero_pen;
    logic              addr_lsb_unused;

    assign addr_lsb_unused = ^in_addr[DW_SHIFT-1:0];

    // Ready comes up one edge after reset release and then stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign in_ready = ready_q;
    assign accept   = in_valid && ready_q;
    assign slot     = in_addr[DW_SHIFT +: SLOT_W];
    assign dw       = in_addr[ADDR_W-1:DW_SHIFT];
    assign mode_e   = fetch_mode_e'(mode_cached);
    assign zero_pen = (mode_e == FETCH_CACHED) || mask_en;

    ifp_seq_tracker #(
        .DW_W      (DW_W),
        .CYC_W     (CYC_W),
        .WIDE_CYC  (WIDE_CYC),
        .CHAIN_WIN (CHAIN_WIN)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .dw        (dw),
        .two_dw    (in_two_dw),
        .cyc       (in_base_cyc),
        .is_target (in_is_target),
        .seq_free  (seq_free)
    );

    ifp_slot_rules #(
        .SLOT_W    (SLOT_W),
        .WIDE_FREE (WIDE_FREE),
        .TGT_FREE  (TGT_FREE),
        .COND_FREE (COND_FREE),
        .UNIT_W    (UNIT_W)
    ) u_rules (
        .slot      (slot),
        .two_dw    (in_two_dw),
        .seq_free  (seq_free),
        .is_target (in_is_target),
        .backward  (in_backward),
        .is_cond   (in_is_cond),
        .taken     (in_taken),
        .units     (units)
    );

    ifp_accum #(
        .UNIT_W (UNIT_W),
        .PEN_W  (PEN_W),
        .TOT_W  (TOT_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .units      (units),
        .zero_pen   (zero_pen),
        .raw_block  (mode_e == FETCH_CACHED),
        .pen_valid  (pen_valid),
        .pen_cycles (pen_cycles),
        .pen_total  (pen_total),
        .raw_total  (raw_total)
    );

    a_r1_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);
    a_r3_single_dw_free: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !mode_cached && !mask_en && !in_two_dw && !in_is_target && !in_is_cond)
        |=> (pen_cycles == '0));
    a_r6_backward_free: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !mode_cached && !mask_en && !in_two_dw && in_is_target && in_backward
         && !in_is_cond) |=> (pen_cycles == '0));
    a_r10_mask_hides: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mask_en) |=> ((pen_cycles == '0) && $stable(pen_total)));
endmodule

// File: tb/tb_ifp_align_penalty.sv
module tb_ifp_align_penalty;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addr = '0;
    logic        in_two_dw = 1'b0;
    logic [7:0]  in_base_cyc = 8'd4;
    logic        in_is_target = 1'b0;
    logic        in_backward = 1'b0;
    logic        in_is_cond = 1'b0;
    logic        in_taken = 1'b0;
    logic        mode_cached = 1'b0;
    logic        mask_en = 1'b0;
    logic        pen_valid;
    logic [5:0]  pen_cycles;
    logic [23:0] pen_total;
    logic [23:0] raw_total;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    bit  m_have = 0;
    int  m_free_end = 0;
    bit  m_chain = 0;
    int  m_chain_dw = 0;
    longint e_tot = 0;
    longint e_raw = 0;

    always #4 clk = ~clk;

    ifp_align_penalty dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_two_dw(in_two_dw), .in_base_cyc(in_base_cyc),
        .in_is_target(in_is_target), .in_backward(in_backward),
        .in_is_cond(in_is_cond), .in_taken(in_taken),
        .mode_cached(mode_cached), .mask_en(mask_en),
        .pen_valid(pen_valid), .pen_cycles(pen_cycles),
        .pen_total(pen_total), .raw_total(raw_total)
    );

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic send(int dw, bit two, int cyc, bit tgt, bit bwd, bit cnd, bit tk,
                        string tag, int lsb = 0);
        int slot = dw % 8;
        bit fr;
        int u = 0;
        int pe;
        int cur_end = dw + (two ? 2 : 1);
        fr = !tgt && m_have && ((cur_end <= m_free_end) ||
             (m_chain && two && dw > m_chain_dw && (dw - m_chain_dw) <= 4));
        if (two && slot >= 2 && !fr) u += 1;
        if (tgt && !bwd && slot > 4) u += slot - 4;
        if (cnd && !tk && slot >= 4) u += slot - 3;
        pe = (mode_cached || mask_en) ? 0 : u * 4;
        e_tot += pe;
        if (!mode_cached) e_raw += u * 4;
        m_have = 1;
        m_free_end = dw + ((cyc > 4) ? cyc / 4 : 0);
        m_chain = two && (cyc >= 16);
        m_chain_dw = dw;
        in_addr = 16'((dw * 4) + lsb);
        in_two_dw = two; in_base_cyc = 8'(cyc);
        in_is_target = tgt; in_backward = bwd; in_is_cond = cnd; in_taken = tk;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "pen_valid", longint'(pen_valid), 1);
        chk(tag, "pen_cycles", longint'(pen_cycles), pe);
        chk("R11", "pen_total", longint'(pen_total), e_tot);
        chk(mask_en ? "R10" : "R11", "raw_total", longint'(raw_total), e_raw);
    endtask

    function automatic string pick_tag(int tv, int cv, bit two);
        if (mode_cached) return "R9";
        if (mask_en) return "R10";
        if (tv == 1 && cv == 1 && two) return "R8";
        if (cv != 0) return "R7";
        if (tv != 0) return "R6";
        return "R3";
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int blk = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "in_ready in reset", longint'(in_ready), 0);
        chk("R1", "pen_valid in reset", longint'(pen_valid), 0);
        chk("R1", "pen_total in reset", longint'(pen_total), 0);
        chk("R1", "raw_total in reset", longint'(raw_total), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", "in_ready after reset", longint'(in_ready), 1);

        // Sweep of slots against flags in all four mode/mask combinations.
        for (int mi = 0; mi < 4; mi++) begin
            mode_cached = mi[0];
            mask_en = mi[1];
            for (int tv = 0; tv < 3; tv++)
                for (int cv = 0; cv < 3; cv++)
                    for (int sz = 0; sz < 2; sz++)
                        for (int sl = 0; sl < 8; sl++) begin
                            blk++;
                            send(blk * 8 + sl, sz[0], 4, tv != 0, tv == 2, cv != 0, cv == 2,
                                 pick_tag(tv, cv, sz[0]), sl % 4);
                        end
        end

        // R2 idle: no pulse and totals stable without acceptance.
        @(posedge clk); @(negedge clk);
        chk("R2", "idle pen_valid", longint'(pen_valid), 0);
        chk("R2", "idle pen_total", longint'(pen_total), e_tot);
        chk("R2", "idle raw_total", longint'(raw_total), e_raw);

        mode_cached = 1'b0; mask_en = 1'b0;
        // R4 free window from a long previous instruction.
        blk += 2;
        send(blk * 8 + 2, 0, 12, 0, 0, 0, 0, "R4");
        send(blk * 8 + 3, 1, 4, 0, 0, 0, 0, "R4");   // ends at +5, window +5: free
        blk += 2;
        send(blk * 8 + 2, 0, 8, 0, 0, 0, 0, "R4");
        send(blk * 8 + 3, 1, 4, 0, 0, 0, 0, "R4");   // window +4: penalty
        blk += 2;
        send(blk * 8 + 2, 0, 12, 0, 0, 0, 0, "R4");
        send(blk * 8 + 3, 1, 4, 1, 0, 0, 0, "R4");   // jump target: not hidden
        // R5 chaining of long two-dword instructions.
        blk += 2;
        send(blk * 8 + 0, 1, 16, 0, 0, 0, 0, "R5");
        send(blk * 8 + 4, 1, 4, 0, 0, 0, 0, "R5");   // gap 4: free
        blk += 2;
        send(blk * 8 + 0, 1, 16, 0, 0, 0, 0, "R5");
        send(blk * 8 + 5, 1, 4, 0, 0, 0, 0, "R5");   // gap 5: penalty
        blk += 2;
        send(blk * 8 + 0, 0, 16, 0, 0, 0, 0, "R5");
        send(blk * 8 + 4, 1, 4, 0, 0, 0, 0, "R5");   // one-dword first: penalty
        blk += 2;
        send(blk * 8 + 0, 1, 12, 0, 0, 0, 0, "R5");
        send(blk * 8 + 4, 1, 4, 0, 0, 0, 0, "R5");   // too short: penalty
        // R8 worst case: 2-dword fall-through branch and forward target at slot 7.
        blk += 2;
        send(blk * 8 + 7, 1, 4, 1, 0, 1, 0, "R8");
        chk("R8", "worst case cycles", longint'(pen_cycles), 32);

        // R1 reset mid-run clears totals.
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1", "pen_total after reset", longint'(pen_total), 0);
        chk("R1", "raw_total after reset", longint'(raw_total), 0);
        chk("R1", "in_ready in reset", longint'(in_ready), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule